// File: doc/BRIEF.md
# SPI Transfer Sequencer

This block runs a single SPI transfer from its first frame to its last on behalf of a register-mapped SPI controller. Software reaches it through a small word-addressed register bus. The bus gives access to a 32-word transmit FIFO, a 32-word receive FIFO, a 20-bit length for each direction, the chip selects and two end-of-transfer interrupts. A separate timing generator does the bit shifting. The sequencer hands it one frame at a time with a start pulse and waits for its done pulse before it issues the next frame.

There are three ways a transfer begins. In plain 4-wire operation, a transmit transfer starts as soon as a word sits in the transmit FIFO. In 3-wire and dual-data-line operation, no frame is issued until software writes a request bit. A receive-only transfer can instead clock a programmed number of frames by itself, sending all-zero data. The transmit-end event fires when the last frame is issued. A separate busy flag stays set until that frame has been fully shifted.

Top module: `spi_xfer_seq`

Register map (word index on `bus_addr`): 0 data (write pushes TX FIFO, read pops RX FIFO), 1 control, 2 chip select, 3 TX length high, 4 TX length low, 5 RX length high, 6 RX length low, 7 receive-only, 8 software request, 9 interrupt enable, 10 interrupt clear, 11 raw status, 12 masked status, 13 status, 14 FIFO reset.

## Requirements
- R1: Each FIFO holds 32 words. A data write made while the TX FIFO is full is dropped, and the stored words keep their order.
- R2: A data read while the RX FIFO is empty returns 0 and removes nothing. Later received words are still read in order.
- R3: While FIFO reset (index 14, bit 0) is 1, both FIFOs are emptied. Words pushed before the reset are never sent or read.
- R4: The TX length is {index 3 bits 3:0, index 4 bits 15:0}, a 20-bit count. Exactly that many TX frames are issued. Raw status bit 8 (TX end) is set in the same cycle that the last one is issued.
- R5: The RX length is {index 5 bits 3:0, index 6 bits 15:0}. Each completed frame with RX enabled stores its received word in the RX FIFO, up to that length. Raw status bit 9 (RX end) is set when the count reaches the length.
- R6: Masked status (index 12) is raw AND enable (index 9), using bits 8 and 9. `irq` is high when any masked bit is high. Writing 1 to a bit of index 10 clears that raw bit.
- R7: Status bit 8 (TX busy) is 1 from the issue of a TX frame until its done pulse. It is therefore still 1 after TX end has been raised, until the final frame finishes.
- R8: Control bit 13 enables TX and bit 12 enables RX. With both at 0 the sequencer is idle: both counts and both pending requests are cleared, so a later transfer starts afresh.
- R9: In receive-only 4-wire operation (control bit 12 only), index 7 holds a 9-bit frame count in bits 8:0 and a start bit in bit 9. While start is 1, that many frames are issued with all-zero TX data. Clearing start rearms the count.
- R10: Control bits 1:0 select the wiring: 0 is 4-wire, 1 is 3-wire, 2 is dual line. In 3-wire or dual mode no frame is issued until index 8 is written with bit 1 (TX) or bit 0 (RX). In 4-wire mode, FIFO data alone starts TX.
- R11: Index 2 bits 11:8 drive the active-low chip selects `cs_n`. They are all 1 (no device selected) after reset.
- R12: At most one frame is outstanding. `frm_start` is a one-cycle pulse, and the next pulse comes no earlier than the cycle after `frm_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX FIFO at index 0) |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| frm_start | output | 1 | One-cycle pulse starting a frame |
| frm_txd | output | WORD_W | Word to shift out, held from `frm_start` |
| frm_done | input | 1 | Pulse from the timing generator: frame finished |
| frm_rxd | input | WORD_W | Word received, valid with `frm_done` |
| cs_n | output | 4 | Active-low chip selects |
| irq | output | 1 | OR of the masked interrupt bits |

## Verification
A register write takes effect at the next clock edge. A TX frame therefore starts one edge after the pushing write has landed. Raw TX end is visible in the same cycle as the final `frm_start`. Raw RX end, the stored RX word and the fall of TX busy all appear one edge after `frm_done`. Reads are combinational, and the bench samples `bus_rdata` one time unit after the falling edge of the read cycle. After each stimulus it waits a window far longer than the frame count times the responder's frame delay before comparing frame counts, transmitted words and status. The one timing-critical check, busy still set after TX end, polls raw status every cycle and reads busy straight away, well inside the six-cycle frame delay of the bench.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  localparam int LEN_W    = 20;
  localparam int LEN_HI_W = 4;
  localparam int LEN_LO_W = 16;
  localparam int RO_W     = 9;
  localparam int CS_W     = 4;
  localparam int ADDR_W   = 4;

  // register word indices
  localparam logic [ADDR_W-1:0] A_DATA   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CSEL   = 4'd2;
  localparam logic [ADDR_W-1:0] A_TXLH   = 4'd3;
  localparam logic [ADDR_W-1:0] A_TXLL   = 4'd4;
  localparam logic [ADDR_W-1:0] A_RXLH   = 4'd5;
  localparam logic [ADDR_W-1:0] A_RXLL   = 4'd6;
  localparam logic [ADDR_W-1:0] A_RXONLY = 4'd7;
  localparam logic [ADDR_W-1:0] A_SWREQ  = 4'd8;
  localparam logic [ADDR_W-1:0] A_IEN    = 4'd9;
  localparam logic [ADDR_W-1:0] A_ICLR   = 4'd10;
  localparam logic [ADDR_W-1:0] A_IRAW   = 4'd11;
  localparam logic [ADDR_W-1:0] A_IMSK   = 4'd12;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd13;
  localparam logic [ADDR_W-1:0] A_FRST   = 4'd14;

  // bit positions software relies on
  localparam int TXE_BIT   = 8;
  localparam int RXE_BIT   = 9;
  localparam int BUSY_BIT  = 8;
  localparam int MTX_BIT   = 13;
  localparam int MRX_BIT   = 12;
  localparam int CS_LSB    = 8;
  localparam int ROGO_BIT  = 9;
  localparam int REQTX_BIT = 1;
  localparam int REQRX_BIT = 0;

  typedef enum logic [1:0] {
    WIRE_4    = 2'd0,
    WIRE_3    = 2'd1,
    WIRE_DUAL = 2'd2
  } wire_mode_e;

  function automatic logic [LEN_W-1:0] len_join(input logic [LEN_HI_W-1:0] hi,
                                               input logic [LEN_LO_W-1:0] lo);
    return {hi, lo};
  endfunction

  // true when one more unit brings cnt to len
  function automatic logic reaches(input logic [LEN_W-1:0] cnt,
                                   input logic [LEN_W-1:0] len);
    return ({1'b0, cnt} + {{LEN_W{1'b0}}, 1'b1}) == {1'b0, len};
  endfunction

  // places the two event bits in a 32-bit register word
  function automatic logic [31:0] evt_word(input logic [1:0] v);
    logic [31:0] w;
    w = '0;
    w[TXE_BIT] = v[0];
    w[RXE_BIT] = v[1];
    return w;
  endfunction

endpackage

// File: rtl/spi_seq_fifo.sv
module spi_seq_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    push,
  input  logic [WORD_W-1:0]       wdata,
  input  logic                    pop,
  output logic [WORD_W-1:0]       head,
  output logic                    empty,
  output logic                    full,
  output logic [$clog2(DEPTH):0]  level
);
  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_q, rd_q;
  logic              do_push, do_pop;

  always_comb begin
    level   = wr_q - rd_q;
    empty   = (level == '0);
    full    = (level == (AW+1)'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && !empty;
    head    = mem[rd_q[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (clr) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q[AW-1:0]] <= wdata;
  end

endmodule

// File: rtl/spi_seq_irq.sv
module spi_seq_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] set_evt,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  input  logic [1:0] en,
  output logic [1:0] raw,
  output logic [1:0] masked,
  output logic       irq
);
  logic [1:0] raw_q;
  logic [1:0] clr_mask;

  always_comb begin
    clr_mask = clr_wr ? clr_bits : 2'b00;
    raw      = raw_q;
    masked   = raw_q & en;
    irq      = |masked;
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 2'b00;
    else        raw_q <= (raw_q & ~clr_mask) | set_evt;
  end

endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  wire_mode_e        wmode,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              ro_start,
  input  logic [RO_W-1:0]   ro_count,
  input  logic              req_tx,
  input  logic              req_rx,
  input  logic              tx_empty,
  input  logic [WORD_W-1:0] tx_head,
  input  logic              rx_full,
  input  logic              frm_done,
  input  logic [WORD_W-1:0] frm_rxd,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_wdata,
  output logic              frm_start,
  output logic [WORD_W-1:0] frm_txd,
  output logic              tx_busy,
  output logic              ev_tx_end,
  output logic              ev_rx_end,
  output logic [LEN_W-1:0]  tx_cnt,
  output logic [LEN_W-1:0]  rx_cnt,
  output logic              seq_idle
);
  logic            busy_q, frm_tx_q, tx_arm_q, rx_arm_q;
  logic [RO_W-1:0] ro_done_q;
  logic            sw_mode, rx_only, tx_left, rx_left, ro_left;
  logic            can_tx, can_ro, done_now, rx_take;

  always_comb begin
    seq_idle  = !tx_en && !rx_en;
    sw_mode   = (wmode != WIRE_4);
    tx_left   = (tx_cnt != tx_len);
    rx_left   = (rx_cnt != rx_len);
    rx_only   = rx_en && !tx_en;
    can_tx    = tx_en && !busy_q && !tx_empty && tx_left && (!sw_mode || tx_arm_q);
    ro_left   = sw_mode ? (rx_arm_q && rx_left)
                        : (ro_start && (ro_done_q != ro_count) && rx_left);
    can_ro    = rx_only && !busy_q && !rx_full && ro_left;
    done_now  = frm_done && busy_q;
    rx_take   = done_now && rx_en && rx_left;
    tx_pop    = can_tx;
    rx_push   = rx_take;
    rx_wdata  = frm_rxd;
    ev_tx_end = can_tx && reaches(tx_cnt, tx_len);
    ev_rx_end = rx_take && reaches(rx_cnt, rx_len);
    tx_busy   = busy_q && frm_tx_q;
  end

  // frame handshake
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_start <= 1'b0;
      frm_txd   <= '0;
      busy_q    <= 1'b0;
      frm_tx_q  <= 1'b0;
    end else begin
      frm_start <= can_tx || can_ro;
      if (can_tx || can_ro) begin
        frm_txd  <= can_tx ? tx_head : '0;
        busy_q   <= 1'b1;
        frm_tx_q <= can_tx;
      end else if (done_now) begin
        busy_q   <= 1'b0;
        frm_tx_q <= 1'b0;
      end
    end
  end

  // length counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else if (seq_idle) begin
      tx_cnt <= '0;
      rx_cnt <= '0;
    end else begin
      if (can_tx)  tx_cnt <= tx_cnt + 1'b1;
      if (rx_take) rx_cnt <= rx_cnt + 1'b1;
    end
  end

  // software request arming for 3-wire and dual-line operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_arm_q <= 1'b0;
      rx_arm_q <= 1'b0;
    end else begin
      if (seq_idle || ev_tx_end)    tx_arm_q <= 1'b0;
      else if (req_tx && sw_mode)   tx_arm_q <= 1'b1;
      if (seq_idle || ev_rx_end)    rx_arm_q <= 1'b0;
      else if (req_rx && sw_mode)   rx_arm_q <= 1'b1;
    end
  end

  // receive-only auto-clock frame count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ro_done_q <= '0;
    else if (!ro_start || seq_idle)     ro_done_q <= '0;
    else if (can_ro && !sw_mode)        ro_done_q <= ro_done_q + 1'b1;
  end

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              frm_start,
  output logic [WORD_W-1:0] frm_txd,
  input  logic              frm_done,
  input  logic [WORD_W-1:0] frm_rxd,
  output logic [3:0]        cs_n,
  output logic              irq
);
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

  // register state
  logic                tx_en_q, rx_en_q, ro_go_q, frst_q;
  wire_mode_e          wmode_q;
  logic [CS_W-1:0]     cs_q;
  logic [LEN_HI_W-1:0] txlh_q, rxlh_q;
  logic [LEN_LO_W-1:0] txll_q, rxll_q;
  logic [RO_W-1:0]     ro_cnt_q;
  logic [1:0]          ien_q;

  // decode
  logic wr_data, wr_iclr, rd_data, req_tx, req_rx;
  logic [1:0] clr_bits;

  // fifo wiring
  logic              tx_pop, tx_empty, tx_full, rx_push, rx_empty, rx_full;
  logic [WORD_W-1:0] tx_head, rx_head, rx_wdata;
  logic [LVL_W-1:0]  tx_level, rx_level;

  // engine / irq wiring
  logic              tx_busy, ev_tx_end, ev_rx_end, seq_idle;
  logic [LEN_W-1:0]  tx_len, rx_len, tx_cnt, rx_cnt;
  logic [1:0]        irq_raw, irq_msk;
  logic              unused_bits;

  always_comb begin
    wr_data  = bus_wr && (bus_addr == A_DATA);
    wr_iclr  = bus_wr && (bus_addr == A_ICLR);
    rd_data  = bus_rd && (bus_addr == A_DATA);
    req_tx   = bus_wr && (bus_addr == A_SWREQ) && bus_wdata[REQTX_BIT];
    req_rx   = bus_wr && (bus_addr == A_SWREQ) && bus_wdata[REQRX_BIT];
    clr_bits = {bus_wdata[RXE_BIT], bus_wdata[TXE_BIT]};
    tx_len   = len_join(txlh_q, txll_q);
    rx_len   = len_join(rxlh_q, rxll_q);
    cs_n     = cs_q;
  end

  assign unused_bits = ^{bus_wdata[31:16], rx_level};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      wmode_q  <= WIRE_4;
      cs_q     <= '1;
      txlh_q   <= '0;
      txll_q   <= '0;
      rxlh_q   <= '0;
      rxll_q   <= '0;
      ro_cnt_q <= '0;
      ro_go_q  <= 1'b0;
      ien_q    <= 2'b00;
      frst_q   <= 1'b0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_CTRL: begin
          tx_en_q <= bus_wdata[MTX_BIT];
          rx_en_q <= bus_wdata[MRX_BIT];
          wmode_q <= wire_mode_e'(bus_wdata[1:0]);
        end
        A_CSEL:   cs_q     <= bus_wdata[CS_LSB +: CS_W];
        A_TXLH:   txlh_q   <= bus_wdata[LEN_HI_W-1:0];
        A_TXLL:   txll_q   <= bus_wdata[LEN_LO_W-1:0];
        A_RXLH:   rxlh_q   <= bus_wdata[LEN_HI_W-1:0];
        A_RXLL:   rxll_q   <= bus_wdata[LEN_LO_W-1:0];
        A_RXONLY: begin
          ro_cnt_q <= bus_wdata[RO_W-1:0];
          ro_go_q  <= bus_wdata[ROGO_BIT];
        end
        A_IEN:    ien_q    <= {bus_wdata[RXE_BIT], bus_wdata[TXE_BIT]};
        A_FRST:   frst_q   <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_DATA:   bus_rdata[WORD_W-1:0] = rx_empty ? '0 : rx_head;
        A_CTRL: begin
          bus_rdata[MTX_BIT] = tx_en_q;
          bus_rdata[MRX_BIT] = rx_en_q;
          bus_rdata[1:0]     = wmode_q;
        end
        A_CSEL:   bus_rdata[CS_LSB +: CS_W] = cs_q;
        A_TXLH:   bus_rdata[LEN_HI_W-1:0]   = txlh_q;
        A_TXLL:   bus_rdata[LEN_LO_W-1:0]   = txll_q;
        A_RXLH:   bus_rdata[LEN_HI_W-1:0]   = rxlh_q;
        A_RXLL:   bus_rdata[LEN_LO_W-1:0]   = rxll_q;
        A_RXONLY: begin
          bus_rdata[RO_W-1:0]  = ro_cnt_q;
          bus_rdata[ROGO_BIT]  = ro_go_q;
        end
        A_IEN:    bus_rdata = evt_word(ien_q);
        A_IRAW:   bus_rdata = evt_word(irq_raw);
        A_IMSK:   bus_rdata = evt_word(irq_msk);
        A_STAT:   bus_rdata[BUSY_BIT] = tx_busy;
        A_FRST:   bus_rdata[0] = frst_q;
        default: ;
      endcase
    end
  end

  spi_seq_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(frst_q),
    .push(wr_data), .wdata(bus_wdata[WORD_W-1:0]),
    .pop(tx_pop), .head(tx_head),
    .empty(tx_empty), .full(tx_full), .level(tx_level)
  );

  spi_seq_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(frst_q),
    .push(rx_push), .wdata(rx_wdata),
    .pop(rd_data), .head(rx_head),
    .empty(rx_empty), .full(rx_full), .level(rx_level)
  );

  spi_seq_engine #(.WORD_W(WORD_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en_q), .rx_en(rx_en_q), .wmode(wmode_q),
    .tx_len(tx_len), .rx_len(rx_len),
    .ro_start(ro_go_q), .ro_count(ro_cnt_q),
    .req_tx(req_tx), .req_rx(req_rx),
    .tx_empty(tx_empty), .tx_head(tx_head), .rx_full(rx_full),
    .frm_done(frm_done), .frm_rxd(frm_rxd),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_wdata(rx_wdata),
    .frm_start(frm_start), .frm_txd(frm_txd),
    .tx_busy(tx_busy), .ev_tx_end(ev_tx_end), .ev_rx_end(ev_rx_end),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .seq_idle(seq_idle)
  );

  spi_seq_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_evt({ev_rx_end, ev_tx_end}),
    .clr_wr(wr_iclr), .clr_bits(clr_bits), .en(ien_q),
    .raw(irq_raw), .masked(irq_msk), .irq(irq)
  );

endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
  parameter int LVL_W = 6,
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_start,
  input logic             tx_busy,
  input logic             ev_tx_end,
  input logic             ev_rx_end,
  input logic [1:0]       irq_raw,
  input logic [1:0]       ien,
  input logic             irq,
  input logic             tx_full,
  input logic             tx_pop,
  input logic             fifo_clr,
  input logic [LVL_W-1:0] tx_level,
  input logic             seq_idle,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !tx_pop && !fifo_clr) |=> (tx_level == $past(tx_level))); // R1

  AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (tx_level == '0)); // R3

  AST_TXEND_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_end |=> irq_raw[0]); // R4

  AST_RXEND_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_end |=> irq_raw[1]); // R5

  AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq); // R6

  AST_BUSY_OUTLASTS_END: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_end |=> tx_busy); // R7

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |=> (tx_cnt == '0 && rx_cnt == '0)); // R8

  AST_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> !frm_start); // R12

endmodule

bind spi_xfer_seq spi_seq_chk #(.LVL_W(LVL_W), .CNT_W(spi_seq_pkg::LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .tx_busy(tx_busy),
  .ev_tx_end(ev_tx_end), .ev_rx_end(ev_rx_end), .irq_raw(irq_raw),
  .ien(ien_q), .irq(irq), .tx_full(tx_full), .tx_pop(tx_pop),
  .fifo_clr(frst_q), .tx_level(tx_level), .seq_idle(seq_idle),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_xfer_seq_bench.sv
module spi_xfer_seq_bench;
  import spi_seq_pkg::*;

  localparam int FD = 6;
  localparam logic [31:0] RXBASE = 32'hC0DE_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frm_start;
  logic [31:0] frm_txd;
  logic        frm_done;
  logic [31:0] frm_rxd;
  logic [3:0]  cs_n;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  int frames = 0, overlap = 0;
  logic [31:0] last_txd = '0;

  always #4 clk = ~clk;

  spi_xfer_seq u_spi_xfer_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frm_start(frm_start), .frm_txd(frm_txd), .frm_done(frm_done),
    .frm_rxd(frm_rxd), .cs_n(cs_n), .irq(irq)
  );

  // wire, len, npush, req, expected frames, expected TX end
  localparam logic [27:0] VEC [6] = '{
    {2'd0, 8'd4, 8'd4, 1'b0, 8'd4, 1'b1},
    {2'd0, 8'd3, 8'd6, 1'b0, 8'd3, 1'b1},
    {2'd0, 8'd5, 8'd2, 1'b0, 8'd2, 1'b0},
    {2'd1, 8'd3, 8'd3, 1'b0, 8'd0, 1'b0},
    {2'd1, 8'd3, 8'd3, 1'b1, 8'd3, 1'b1},
    {2'd2, 8'd2, 8'd4, 1'b1, 8'd2, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    wr(A_CTRL, 32'h0);
    wr(A_RXONLY, 32'h0);
    wr(A_FRST, 32'h1);
    wr(A_FRST, 32'h0);
    wr(A_ICLR, 32'h300);
  endtask

  // timing generator model
  initial begin
    frm_done = 1'b0;
    frm_rxd  = '0;
    forever begin
      @(negedge clk);
      if (frm_start) begin
        frames++;
        last_txd = frm_txd;
        for (int k = 0; k < FD - 1; k++) begin
          @(negedge clk);
          if (frm_start) overlap++;
        end
        frm_rxd  = RXBASE + 32'(frames);
        frm_done = 1'b1;
        @(negedge clk);
        if (frm_start) overlap++;
        frm_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(A_CSEL, d);  chk("R11 reset cs", d, 32'hF00);
    chk("R11 cs_n pin", {28'h0, cs_n}, 32'hF);
    rd(A_IRAW, d);  chk("R6 reset raw", d, 32'h0);
    rd(A_STAT, d);  chk("R7 reset busy", d, 32'h0);
    chk("R6 reset irq", {31'h0, irq}, 32'h0);
    rd(A_DATA, d);  chk("R2 empty read", d, 32'h0);

    // table of TX transfers
    for (int v = 0; v < 6; v++) begin
      logic [27:0] e;
      e = VEC[v];
      go_idle();
      base = frames;
      wr(A_TXLH, 32'h0);
      wr(A_TXLL, {24'h0, e[25:18]});
      wr(A_CTRL, (32'h1 << MTX_BIT) | {30'h0, e[27:26]});
      for (int i = 0; i < int'(e[17:10]); i++) wr(A_DATA, 32'h1000_0000 + 32'(v * 16 + i));
      if (e[9]) wr(A_SWREQ, 32'h2);
      settle(120);
      chk(e[27:26] == 2'd0 ? "R4 frames" : "R10 frames", 32'(frames - base), {24'h0, e[8:1]});
      rd(A_IRAW, d);
      chk("R4 tx end raw", {31'h0, d[TXE_BIT]}, {31'h0, e[0]});
      rd(A_STAT, d);
      chk("R7 busy after", d, 32'h0);
      if (e[8:1] != 0)
        chk("R4 last word", last_txd, 32'h1000_0000 + 32'(v * 16) + 32'(e[8:1]) - 1);
    end

    // R4: upper length bits take part
    go_idle();
    base = frames;
    wr(A_TXLH, 32'h1);
    wr(A_TXLL, 32'h2);
    wr(A_CTRL, 32'h1 << MTX_BIT);
    for (int i = 0; i < 3; i++) wr(A_DATA, 32'h2000 + 32'(i));
    settle(80);
    chk("R4 high length frames", 32'(frames - base), 32'd3);
    rd(A_IRAW, d); chk("R4 high length no end", d, 32'h0);

    // R1: full TX FIFO drops the 33rd word
    go_idle();
    wr(A_TXLH, 32'h0);
    wr(A_TXLL, 32'd40);
    for (int i = 0; i < 33; i++) wr(A_DATA, 32'h3000 + 32'(i));
    base = frames;
    wr(A_CTRL, 32'h1 << MTX_BIT);
    settle(400);
    chk("R1 frames from full fifo", 32'(frames - base), 32'd32);
    chk("R1 last word", last_txd, 32'h3000 + 32'd31);

    // R5: full duplex, received words stored
    go_idle();
    base = frames;
    wr(A_TXLL, 32'd3);
    wr(A_RXLH, 32'h0);
    wr(A_RXLL, 32'd3);
    wr(A_CTRL, (32'h1 << MTX_BIT) | (32'h1 << MRX_BIT));
    for (int i = 0; i < 3; i++) wr(A_DATA, 32'h4000 + 32'(i));
    settle(80);
    rd(A_IRAW, d); chk("R5 both ends raw", d, 32'h300);
    for (int i = 0; i < 3; i++) begin
      rd(A_DATA, d);
      chk("R5 rx word", d, RXBASE + 32'(base + i + 1));
    end
    rd(A_DATA, d); chk("R2 empty after drain", d, 32'h0);

    // R8: lengths reached, more data does nothing until idle
    base = frames;
    wr(A_DATA, 32'h4100);
    settle(40);
    chk("R8 no frame past length", 32'(frames - base), 32'd0);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, (32'h1 << MTX_BIT) | (32'h1 << MRX_BIT));
    settle(40);
    chk("R8 restart after idle", 32'(frames - base), 32'd1);

    // R6: enable, mask, write-1-to-clear
    wr(A_IEN, 32'h0);
    rd(A_IMSK, d); chk("R6 masked off", d, 32'h0);
    chk("R6 irq off", {31'h0, irq}, 32'h0);
    wr(A_IEN, 32'h200);
    rd(A_IMSK, d); chk("R6 masked rx", d, 32'h200);
    chk("R6 irq on", {31'h0, irq}, 32'h1);
    wr(A_ICLR, 32'h200);
    rd(A_IRAW, d); chk("R6 clear rx only", d, 32'h100);
    chk("R6 irq after clear", {31'h0, irq}, 32'h0);
    wr(A_ICLR, 32'h100);
    rd(A_IRAW, d); chk("R6 clear tx", d, 32'h0);
    wr(A_IEN, 32'h0);

    // R7: busy outlasts TX end
    go_idle();
    wr(A_TXLL, 32'd1);
    wr(A_CTRL, 32'h1 << MTX_BIT);
    wr(A_DATA, 32'h5000);
    for (int i = 0; i < 20; i++) begin
      rd(A_IRAW, d);
      if (d[TXE_BIT]) break;
    end
    rd(A_STAT, d); chk("R7 busy after tx end", d, 32'h100);
    settle(20);
    rd(A_STAT, d); chk("R7 busy cleared", d, 32'h0);

    // R3: FIFO reset discards queued words
    go_idle();
    wr(A_CTRL, 32'h0);
    for (int i = 0; i < 3; i++) wr(A_DATA, 32'h6000 + 32'(i));
    wr(A_FRST, 32'h1);
    wr(A_FRST, 32'h0);
    base = frames;
    wr(A_TXLL, 32'd3);
    wr(A_CTRL, 32'h1 << MTX_BIT);
    settle(40);
    chk("R3 nothing sent after reset", 32'(frames - base), 32'd0);

    // R9: receive-only auto-clock
    go_idle();
    base = frames;
    wr(A_RXLL, 32'd5);
    wr(A_CTRL, 32'h1 << MRX_BIT);
    wr(A_RXONLY, (32'h1 << ROGO_BIT) | 32'd4);
    settle(80);
    chk("R9 auto frames", 32'(frames - base), 32'd4);
    chk("R9 zero tx data", last_txd, 32'h0);
    rd(A_IRAW, d); chk("R9 no end yet", d, 32'h0);
    wr(A_RXONLY, 32'h0);
    wr(A_RXONLY, (32'h1 << ROGO_BIT) | 32'd1);
    settle(30);
    chk("R9 reload frames", 32'(frames - base), 32'd5);
    rd(A_IRAW, d); chk("R5 rx end at length", d, 32'h200);
    rd(A_DATA, d); chk("R2 first word after empty reads", d, RXBASE + 32'(base + 1));
    wr(A_FRST, 32'h1);
    wr(A_FRST, 32'h0);
    rd(A_DATA, d); chk("R3 rx fifo emptied", d, 32'h0);

    // R10: 3-wire receive needs request
    go_idle();
    base = frames;
    wr(A_RXLL, 32'd2);
    wr(A_CTRL, (32'h1 << MRX_BIT) | 32'h1);
    settle(40);
    chk("R10 no rx without request", 32'(frames - base), 32'd0);
    wr(A_SWREQ, 32'h1);
    settle(40);
    chk("R10 rx after request", 32'(frames - base), 32'd2);
    rd(A_IRAW, d); chk("R10 rx end", d, 32'h200);

    // R11: chip selects
    wr(A_CSEL, 32'hE00);
    chk("R11 select device 0", {28'h0, cs_n}, 32'hE);
    wr(A_CSEL, 32'hF00);
    chk("R11 deselect all", {28'h0, cs_n}, 32'hF);

    // R12: never two frames outstanding
    chk("R12 frame overlap", 32'(overlap), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule